// File: doc/BRIEF.md
# Carry-Free Redundant-Digit Adder

This block adds two long integers held as vectors of signed digits. Each digit lies in the closed range [-M, M] and carries the weight B^i. Every digit position works out its own result from its own operand pair and the pair directly below it. No carry chain runs across the word, so the depth of the logic is the same for any digit count N.

Each position forms the raw sum of its two digits. It compares that sum with the thresholds -M and +M and emits a transfer of -1, 0 or +1 to the position above, keeping the remainder as an interim digit. It then adds the transfer that arrives from below. Position 0 receives no transfer. The transfer leaving the top position is not folded into the result; it is shown on a separate output, so the caller can confirm that the sum is exact modulo B^N.

A parameter picks how the result is presented. In the registered form, an input strobe captures the result and shows it one cycle later, together with a matching valid pulse. In the pass-through form, the result follows the inputs in the same cycle. The defaults (M=100, B=128) satisfy M < B < 2M, which keeps every output digit inside [-M, M].

Top module: `sd_add_top`

## Requirements
- R1: For in-range operands, the output digits plus out_xfer times B^N equal X + Y exactly, where a vector's value is the sum over i of digit_i times B^i.
- R2: Whenever z_vld is high, every output digit lies in [-M, M], given operand digits in [-M, M].
- R3: The transfer out of position i is +1 when x_i + y_i >= M, -1 when x_i + y_i <= -M, and 0 otherwise. The interim digit is the raw sum minus B times that transfer.
- R4: Output digit 0 equals its own interim digit, because no transfer enters position 0.
- R5: Output digit i (for i > 0) equals its interim digit plus the transfer out of position i-1. The transfer out of position N-1 appears only on out_xfer, coded in 2-bit two's complement: 2'b01 = +1, 2'b00 = 0, 2'b11 = -1. The code 2'b10 never appears.
- R6: With REG=1, a cycle with in_vld high is followed by exactly one cycle of z_vld high. In that cycle z_dig and out_xfer show the result of the operands that were sampled.
- R7: With REG=1, operands presented while in_vld is low are ignored. z_dig and out_xfer keep their previous values, and z_vld is low in the next cycle.
- R8: While rst_n is low (asynchronous, active low), z_vld is 0, z_dig is all zeros and out_xfer is 2'b00.
- R9: With REG=0, z_vld equals in_vld, and z_dig and out_xfer show the result of the present operands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand strobe |
| x_dig | input | N*W | First operand; digit i at bits [i*W +: W], two's complement |
| y_dig | input | N*W | Second operand, same packing |
| z_dig | output | N*W | Sum digits, same packing |
| z_vld | output | 1 | Result valid |
| out_xfer | output | 2 | Transfer out of the top position (-1, 0, +1) |

## Verification
Every output digit depends on two things: the transfer that leaves its own position and the transfer that arrives from below. Both can push the digit to a bound of [-M, M] in the same cycle. The stimulus provokes this with alternating patterns. In one, a position whose raw sum is exactly M sits under a position whose raw sum is M-1, so the upper digit must land on +M. The mirrored pattern, with raw sums of -M and -(M-1), must land on -M. Each such result is judged three ways: digit by digit against a threshold model of the transfers, as an exact wide-integer value that counts the dropped top transfer, and against the digit bounds.

// File: rtl/sd_add_pkg.sv
`timescale 1ns/1ps
package sd_add_pkg;

  // Transfer between digit positions, two's complement: 01=+1, 00=0, 11=-1
  typedef logic signed [1:0] xfer_t;

  localparam xfer_t XF_NEG  = 2'b11;
  localparam xfer_t XF_NONE = 2'b00;
  localparam xfer_t XF_POS  = 2'b01;

  // Decide the transfer leaving a position from its raw digit sum
  function automatic xfer_t classify_sum(input int raw, input int bound);
    if (raw >= bound)       return XF_POS;
    else if (raw <= -bound) return XF_NEG;
    else                    return XF_NONE;
  endfunction

  // Remainder kept by a position once its transfer has been taken out
  function automatic int reduce_sum(input int raw, input int bound, input int radix);
    if (raw >= bound)       return raw - radix;
    else if (raw <= -bound) return raw + radix;
    else                    return raw;
  endfunction

endpackage

// File: rtl/sd_digit_split.sv
`timescale 1ns/1ps
module sd_digit_split
  import sd_add_pkg::*;
#(
  parameter int W = 8,
  parameter int M = 100,
  parameter int B = 128
) (
  input  logic signed [W-1:0] xd,
  input  logic signed [W-1:0] yd,
  output xfer_t               xfer,
  output logic signed [W-1:0] interim
);

  // One extra bit holds the raw sum, whose magnitude is at most 2M
  localparam int SW = W + 1;

  logic signed [SW-1:0] raw_sum;
  int                   raw_i;
  int                   red_i;

  assign raw_sum = SW'(xd) + SW'(yd);

  always_comb begin
    raw_i   = int'(raw_sum);
    xfer    = classify_sum(raw_i, M);
    red_i   = reduce_sum(raw_i, M, B);
    interim = W'(red_i);
  end

endmodule

// File: rtl/sd_digit_absorb.sv
`timescale 1ns/1ps
module sd_digit_absorb
  import sd_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic signed [W-1:0] interim,
  input  xfer_t               xin,
  output logic signed [W-1:0] zd
);

  // The bounds on M and B keep this sum inside [-M, M], so no further transfer
  assign zd = interim + W'(xin);

endmodule

// File: rtl/sd_add_core.sv
`timescale 1ns/1ps
module sd_add_core
  import sd_add_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  parameter int M = 100,
  parameter int B = 128
) (
  input  logic [N*W-1:0] x_vec,
  input  logic [N*W-1:0] y_vec,
  output logic [N*W-1:0] z_vec,
  output xfer_t          top_xfer
);

  xfer_t               xf_out [N];
  xfer_t               xf_in  [N];
  logic signed [W-1:0] mid    [N];

  for (genvar i = 0; i < N; i++) begin : g_pos
    sd_digit_split #(.W(W), .M(M), .B(B)) u_split (
      .xd      (x_vec[i*W +: W]),
      .yd      (y_vec[i*W +: W]),
      .xfer    (xf_out[i]),
      .interim (mid[i])
    );

    if (i == 0) begin : g_base
      assign xf_in[i] = XF_NONE;
    end else begin : g_link
      assign xf_in[i] = xf_out[i-1];
    end

    sd_digit_absorb #(.W(W)) u_absorb (
      .interim (mid[i]),
      .xin     (xf_in[i]),
      .zd      (z_vec[i*W +: W])
    );
  end

  assign top_xfer = xf_out[N-1];

endmodule

// File: rtl/sd_add_top.sv
`timescale 1ns/1ps
module sd_add_top
  import sd_add_pkg::*;
#(
  parameter int N   = 8,
  parameter int W   = 8,
  parameter int M   = 100,
  parameter int B   = 128,
  parameter bit REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [N*W-1:0] x_dig,
  input  logic [N*W-1:0] y_dig,
  output logic [N*W-1:0] z_dig,
  output logic           z_vld,
  output logic [1:0]     out_xfer
);

  localparam int VW = N * W;

  // Named results of the parallel stage, visible to the checker
  logic [VW-1:0] sum_z;
  xfer_t         sum_xf;

  sd_add_core #(.N(N), .W(W), .M(M), .B(B)) u_core (
    .x_vec    (x_dig),
    .y_vec    (y_dig),
    .z_vec    (sum_z),
    .top_xfer (sum_xf)
  );

  if (REG) begin : g_reg
    logic [VW-1:0] z_q;
    xfer_t         xf_q;
    logic          v_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        z_q  <= '0;
        xf_q <= XF_NONE;
        v_q  <= 1'b0;
      end else begin
        v_q <= in_vld;
        if (in_vld) begin
          z_q  <= sum_z;
          xf_q <= sum_xf;
        end
      end
    end

    assign z_dig    = z_q;
    assign out_xfer = xf_q;
    assign z_vld    = v_q;
  end else begin : g_pass
    assign z_dig    = sum_z;
    assign out_xfer = sum_xf;
    assign z_vld    = in_vld;
  end

endmodule

// File: rtl/sd_add_chk.sv
`timescale 1ns/1ps
module sd_add_chk #(
  parameter int N   = 8,
  parameter int W   = 8,
  parameter int M   = 100,
  parameter bit REG = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic [N*W-1:0] z_dig,
  input logic           z_vld,
  input logic [1:0]     out_xfer
);

  for (genvar i = 0; i < N; i++) begin : g_dig
    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      z_vld |-> ($signed(z_dig[i*W +: W]) <= M && $signed(z_dig[i*W +: W]) >= -M));
  end

  // R5
  xfer_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_xfer != 2'b10);

  if (REG) begin : g_reg_chk
    // R6
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> z_vld);

    // R7
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !z_vld);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(z_dig) && $stable(out_xfer)));
  end

endmodule

bind sd_add_top sd_add_chk #(.N(N), .W(W), .M(M), .REG(REG)) u_sd_add_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .z_dig    (z_dig),
  .z_vld    (z_vld),
  .out_xfer (out_xfer)
);

// File: tb/test_sd_add_top.sv
`timescale 1ns/1ps
module test_sd_add_top;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int M  = 100;
  localparam int B  = 128;
  localparam int VW = N * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [VW-1:0] x_dig = '0;
  logic [VW-1:0] y_dig = '0;
  logic [VW-1:0] z_dig, zc_dig;
  logic          z_vld, zc_vld;
  logic [1:0]    out_xfer, outc_xfer;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  sd_add_top #(.N(N), .W(W), .M(M), .B(B), .REG(1'b1)) i_sd_add_top (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_dig(x_dig), .y_dig(y_dig),
    .z_dig(z_dig), .z_vld(z_vld), .out_xfer(out_xfer));

  sd_add_top #(.N(N), .W(W), .M(M), .B(B), .REG(1'b0)) i_sd_add_top_comb (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_dig(x_dig), .y_dig(y_dig),
    .z_dig(zc_dig), .z_vld(zc_vld), .out_xfer(outc_xfer));

  // Reference state: the result the registered copy should be holding
  int xa [N];
  int ya [N];
  int exp_z [N];
  int exp_top;
  int reg_z [N];
  int reg_top = 0;
  bit reg_vld = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dig(input logic [VW-1:0] v, input int i);
    return int'($signed(v[i*W +: W]));
  endfunction

  // Model: choose each transfer by threshold, then let it leave its digit
  function automatic void model();
    int t [N+1];
    t[0] = 0;
    for (int i = 0; i < N; i++) begin
      int s = xa[i] + ya[i];
      t[i+1] = (s >= M) ? 1 : ((s <= -M) ? -1 : 0);
    end
    for (int i = 0; i < N; i++)
      exp_z[i] = xa[i] + ya[i] - B * t[i+1] + t[i];
    exp_top = t[N];
  endfunction

  task automatic check_result(input string tag, input logic [VW-1:0] zv,
                              input logic [1:0] xv);
    longint lhs = 0;
    longint rhs = 0;
    longint w = 1;
    for (int i = 0; i < N; i++) begin
      lhs += longint'(dig(zv, i)) * w;
      rhs += longint'(xa[i] + ya[i]) * w;
      w   *= B;
    end
    lhs += longint'($signed(xv)) * w;
    check({tag, " R1 exact value"}, lhs, rhs);
    check({tag, " R4 digit0"}, dig(zv, 0), exp_z[0]);
    for (int i = 1; i < N; i++)
      check({tag, " R3 digit"}, dig(zv, i), exp_z[i]);
    for (int i = 0; i < N; i++)
      check({tag, " R2 in range"}, longint'(dig(zv, i) >= -M && dig(zv, i) <= M), 1);
    check({tag, " R5 top transfer"}, int'($signed(xv)), exp_top);
  endtask

  // One clock: drive at the falling edge, judge both copies away from edges
  task automatic cycle(input bit vld);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      x_dig[i*W +: W] = W'(xa[i]);
      y_dig[i*W +: W] = W'(ya[i]);
    end
    in_vld = vld;
    model();
    #1;
    check("R9 comb valid", zc_vld, vld);
    if (vld) check_result("R9 comb", zc_dig, outc_xfer);
    @(posedge clk);
    #1;
    if (vld) begin
      for (int i = 0; i < N; i++) reg_z[i] = exp_z[i];
      reg_top = exp_top;
    end
    reg_vld = vld;
    check("R6 z_vld", z_vld, reg_vld);
    for (int i = 0; i < N; i++)
      check(vld ? "R6 registered digit" : "R7 held digit", dig(z_dig, i), reg_z[i]);
    check(vld ? "R6 registered transfer" : "R7 held transfer",
          int'($signed(out_xfer)), reg_top);
    if (vld) begin
      for (int i = 0; i < N; i++) exp_z[i] = reg_z[i];
      exp_top = reg_top;
      check_result("R6 reg", z_dig, out_xfer);
    end
  endtask

  task automatic fill(input int xv0, input int yv0, input int xv1, input int yv1);
    for (int i = 0; i < N; i++) begin
      xa[i] = (i % 2 == 0) ? xv0 : xv1;
      ya[i] = (i % 2 == 0) ? yv0 : yv1;
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < N; i++) begin
      xa[i] = int'($urandom_range(2 * M)) - M;
      ya[i] = int'($urandom_range(2 * M)) - M;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      xa[i] = 0; ya[i] = 0; reg_z[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R8
    check("R8 reset z_vld", z_vld, 0);
    check("R8 reset z_dig", longint'(z_dig == '0), 1);
    check("R8 reset out_xfer", out_xfer, 0);
    @(negedge clk);
    rst_n = 1'b1;

    fill(0, 0, 0, 0);            cycle(1'b1);
    fill(M, 0, M - 1, 0);        cycle(1'b1);   // +M under M-1: digit lands on +M
    fill(-M, 0, -(M - 1), 0);    cycle(1'b1);   // mirrored: digit lands on -M
    fill(M, M, M, M);            cycle(1'b1);
    fill(-M, -M, -M, -M);        cycle(1'b1);
    fill(M - 1, 0, M - 1, 0);    cycle(1'b1);
    fill(-(M - 1), 0, M, 0);     cycle(1'b1);
    fill(M, -M, -M, M);          cycle(1'b1);
    fill(M, 0, -M, 0);           cycle(1'b1);
    // R7: operands change with no strobe
    fill(M, M, -M, -M);          cycle(1'b0);
    fill_random();               cycle(1'b0);

    for (int k = 0; k < 400; k++) begin
      fill_random();
      cycle(($urandom_range(3) != 0) ? 1'b1 : 1'b0);
    end
    cycle(1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule